// File: doc/BRIEF.md
# USB Clock Request Controller

This block decides when the 48 MHz USB clock and the bus-master clock of a USB host/device controller pair must run. Hardware requests come from three sources. The device-side DMA and the host-side DMA each keep the bus-master clock alive. After each DMA access they hold that clock on for two USB frames, timed by a 1 ms tick. The host's functional state and its bus events keep the 48 MHz clock alive.

Each clock's gate enable is the OR of its software enable bit and its hardware request. Software can therefore clear its enable bits during normal traffic and the clocks still run while they are needed. Each gate enable is returned as a clock-on status bit after a short synchroniser, so software can poll for it after setting an enable. A combined need-clock flag tells firmware whether any hardware request is still pending, so it can wait for that flag to clear before it enters power-down.

Top module: `usb_clk_req_ctrl`

## Requirements
- R1: A device DMA access strobe asserts the bus-master gate enable (bit 1) and `need_clk_o` in the same cycle.
- R2: After the last access, the DMA request stays high until the second `ms_tick_i` pulse. It is still high during the cycle of that tick and low in the cycle after it. A tick while the request is idle has no effect.
- R3: An access in the same cycle as a tick reloads the hold count to two. Any access during the hold restarts the full two-tick period.
- R4: Host DMA access strobes drive a second, independent hold timer with the same behaviour as the device timer, and that timer also requests the bus-master clock.
- R5: The host 48 MHz request, gate bit 0, is high whenever `host_state_i` is not suspend. The state encoding is 00 reset, 01 resume, 10 operational and 11 suspend.
- R6: While the host is in suspend, a resume detect or a disconnect detect still asserts the 48 MHz request.
- R7: Each bit of `clk_gate_en_o` equals the OR of the matching `sw_clk_en_i` bit and that clock's hardware request. Bit 0 is the USB 48 MHz clock and bit 1 is the bus-master clock.
- R8: `need_clk_o` is the OR of the three hardware requests and does not depend on `sw_clk_en_i`.
- R9: `clk_on_o` equals `clk_gate_en_o` delayed by exactly two clock cycles.
- R10: Reset clears both hold timers and the clock-on status at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_dma_acc_i | input | 1 | Device DMA memory access strobe |
| host_dma_acc_i | input | 1 | Host DMA memory access strobe |
| host_state_i | input | 2 | Host functional state (00 reset, 01 resume, 10 operational, 11 suspend) |
| host_resume_i | input | 1 | Resume signalling detected on the bus |
| host_disc_i | input | 1 | Disconnect detected on the bus |
| ms_tick_i | input | 1 | One-cycle pulse per 1 ms frame |
| sw_clk_en_i | input | 2 | Software clock enables (bit 0 USB 48 MHz, bit 1 bus master) |
| clk_gate_en_o | output | 2 | Clock gate enables |
| clk_on_o | output | 2 | Synchronised clock-on status |
| need_clk_o | output | 1 | OR of all hardware clock requests |

## Verification
A DMA access strobe and a frame tick can arrive in the same cycle, and the two act on the same hold counter. The bench provokes this by driving both together, both while the counter is idle and while it is mid-hold. It judges the outcome by the bus-master enable: it must stay high through two more ticks and drop only after the second one, which shows that the reload won over the decrement. Retriggering one tick before expiry is checked the same way, by counting the ticks until the bus-master enable falls.

// File: rtl/usb_clk_req_pkg.sv
package usb_clk_req_pkg;
  typedef enum logic [1:0] {
    HST_RESET   = 2'b00,
    HST_RESUME  = 2'b01,
    HST_OPER    = 2'b10,
    HST_SUSPEND = 2'b11
  } host_state_e;

  localparam int unsigned CLK_USB = 0;
  localparam int unsigned CLK_BM  = 1;
  localparam int unsigned NUM_CLK = 2;
  localparam int unsigned NUM_DMA = 2;
  localparam int unsigned DMA_DEV  = 0;
  localparam int unsigned DMA_HOST = 1;
endpackage

// File: rtl/usb_dma_hold_timer.sv
module usb_dma_hold_timer #(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic tick_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] cnt_q;

  // reload has priority over decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (acc_i)                 cnt_q <= CW'(HOLD_TICKS);
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign req_o = acc_i || (cnt_q != '0);
endmodule

// File: rtl/usb_host_clk_req.sv
module usb_host_clk_req
  import usb_clk_req_pkg::*;
(
  input  logic [1:0] state_i,
  input  logic       resume_i,
  input  logic       disc_i,
  output logic       req_o
);
  host_state_e st;

  always_comb begin
    st    = host_state_e'(state_i);
    req_o = (st != HST_SUSPEND) || resume_i || disc_i;
  end
endmodule

// File: rtl/usb_clk_on_sync.sv
module usb_clk_on_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/usb_clk_req_ctrl.sv
module usb_clk_req_ctrl
  import usb_clk_req_pkg::*;
#(
  parameter int unsigned HOLD_TICKS  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dev_dma_acc_i,
  input  logic         host_dma_acc_i,
  input  logic [1:0]   host_state_i,
  input  logic         host_resume_i,
  input  logic         host_disc_i,
  input  logic         ms_tick_i,
  input  logic [1:0]   sw_clk_en_i,
  output logic [1:0]   clk_gate_en_o,
  output logic [1:0]   clk_on_o,
  output logic         need_clk_o
);
  logic [NUM_DMA-1:0] dma_acc;
  logic [NUM_DMA-1:0] dma_req;
  logic               usb_req;
  logic [NUM_CLK-1:0] hw_req;

  assign dma_acc[DMA_DEV]  = dev_dma_acc_i;
  assign dma_acc[DMA_HOST] = host_dma_acc_i;

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
    usb_dma_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (dma_acc[g]),
      .tick_i (ms_tick_i),
      .req_o  (dma_req[g])
    );
  end

  usb_host_clk_req u_host_req (
    .state_i  (host_state_i),
    .resume_i (host_resume_i),
    .disc_i   (host_disc_i),
    .req_o    (usb_req)
  );

  assign hw_req[CLK_USB] = usb_req;
  assign hw_req[CLK_BM]  = |dma_req;

  assign clk_gate_en_o = sw_clk_en_i | hw_req;
  assign need_clk_o    = |hw_req;

  usb_clk_on_sync #(.WIDTH(NUM_CLK), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (clk_gate_en_o),
    .q_o    (clk_on_o)
  );
endmodule

// File: rtl/usb_clk_req_ctrl_chk.sv
module usb_clk_req_ctrl_chk
  import usb_clk_req_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dev_dma_acc_i,
  input logic       host_dma_acc_i,
  input logic [1:0] host_state_i,
  input logic       host_resume_i,
  input logic       host_disc_i,
  input logic       ms_tick_i,
  input logic [1:0] sw_clk_en_i,
  input logic [1:0] clk_gate_en_o,
  input logic [1:0] clk_on_o,
  input logic       need_clk_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  p_dev_acc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_dma_acc_i |-> (need_clk_o && clk_gate_en_o[CLK_BM]));

  p_dev_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_dma_acc_i |=> clk_gate_en_o[CLK_BM]);

  p_tick_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_dma_acc_i && ms_tick_i) |=> need_clk_o);

  p_host_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_dma_acc_i |=> (need_clk_o && clk_gate_en_o[CLK_BM]));

  p_host_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_state_i != HST_SUSPEND) |-> (need_clk_o && clk_gate_en_o[CLK_USB]));

  p_bus_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_resume_i || host_disc_i) |-> clk_gate_en_o[CLK_USB]);

  p_sw_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_gate_en_o & sw_clk_en_i) == sw_clk_en_i);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !need_clk_o |-> (clk_gate_en_o == sw_clk_en_i));

  p_clk_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (clk_on_o == $past(clk_gate_en_o, 2)));
endmodule

bind usb_clk_req_ctrl usb_clk_req_ctrl_chk u_chk (.*);

// File: tb/usb_clk_req_ctrl_tb.sv
module usb_clk_req_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       dev_acc, host_acc, tick, resume, disc;
  logic [1:0] state, sw;
  logic [1:0] gate, clk_on;
  logic       need;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_clk_req_ctrl u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .dev_dma_acc_i (dev_acc),
    .host_dma_acc_i(host_acc),
    .host_state_i  (state),
    .host_resume_i (resume),
    .host_disc_i   (disc),
    .ms_tick_i     (tick),
    .sw_clk_en_i   (sw),
    .clk_gate_en_o (gate),
    .clk_on_o      (clk_on),
    .need_clk_o    (need)
  );

  // {dev_acc, host_acc, tick, state[1:0], resume, disc, sw[1:0], exp_gate[1:0], exp_need}
  localparam int NV = 21;
  localparam logic [11:0] VEC [NV] = '{
    12'b000110000000, // idle suspend
    12'b100110000101, // R1 device access
    12'b001110000101, // R2 tick 2->1
    12'b000110000101,
    12'b001110000101, // R2 tick 1->0, still high
    12'b000110000000, // R2 dropped
    12'b101110000101, // R3 access with tick
    12'b001110000101,
    12'b100110000101, // R3 retrigger
    12'b001110000101,
    12'b001110000101,
    12'b000110000000,
    12'b010110000101, // R4 host access
    12'b001100000111, // R5 operational
    12'b001111000111, // R6 resume in suspend
    12'b000110100011, // R6 disconnect
    12'b000110011110, // R7/R8 sw enables only
    12'b000000000011, // R5 reset state
    12'b000010000011, // R5 resume state
    12'b001110000000, // R2 idle tick
    12'b000110000000
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle();
    dev_acc = 0; host_acc = 0; tick = 0; resume = 0; disc = 0;
    state = 2'b11; sw = 2'b00;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    #1;
    check("R10 reset state", {gate, need}, 3'b000);
    check("R10 reset clk_on", {1'b0, clk_on}, 3'b000);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {dev_acc, host_acc, tick, state, resume, disc, sw} = VEC[i][11:3];
      #1;
      check($sformatf("R1/R2/R3/R4/R5/R6/R7/R8 vec %0d", i), {gate, need}, VEC[i][2:0]);
    end

    // R9: clk_on follows gate after two edges
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    sw = 2'b01;
    @(negedge clk); #1;
    check("R9 one edge", {1'b0, clk_on}, 3'b000);
    @(negedge clk); #1;
    check("R9 two edges", {1'b0, clk_on}, 3'b001);
    sw = 2'b00;
    @(negedge clk); #1;
    check("R9 fall one edge", {1'b0, clk_on}, 3'b001);
    @(negedge clk); #1;
    check("R9 fall two edges", {1'b0, clk_on}, 3'b000);

    // R3: access with tick mid-hold; needs two further ticks
    dev_acc = 1;
    @(negedge clk); dev_acc = 0; tick = 1;   // count 2 -> 1
    @(negedge clk); dev_acc = 1; tick = 1;   // reload to 2
    @(negedge clk); dev_acc = 0; tick = 1;   // 2 -> 1
    #1 check("R3 mid-hold reload first tick", {gate, need}, 3'b101);
    @(negedge clk); tick = 0;
    #1 check("R3 mid-hold reload still held", {gate, need}, 3'b101);
    tick = 1;
    @(negedge clk); tick = 0;
    #1 check("R3 mid-hold reload expired", {gate, need}, 3'b000);

    // R10: reset during hold clears the timer and status
    sw = 2'b10; host_acc = 1;
    @(negedge clk); host_acc = 0; sw = 2'b00;
    #1 check("R4 hold before reset", {gate, need}, 3'b101);
    rst_ni = 1'b0;
    #1;
    check("R10 hold cleared", {gate, need}, 3'b000);
    check("R10 clk_on cleared", {1'b0, clk_on}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R10 stays clear", {gate, need}, 3'b000);

    summary();
  end
endmodule